// File: doc/BRIEF.md
# Per-Bit Interrupt Router with Independent Replay

This block serves one interrupt group. A word of source lines, gated by an accumulated enable word, feeds a set of output interrupts, with one output per low-order bit of the word. Each of those bits has its own status flag, its own pending flag and its own output line. An event on a bit that is free raises that bit's status and output at once. An event on a bit that is busy (status already set) or masked is held as pending, and other bits are not affected.

Firmware reads the status word to find which sources fired. It clears bits one by one as it services them. Each written bit either replays a held event on that bit or drops that bit's output. Writing all ones clears the status word to reinitialise it and does nothing else. The enable register has two roles. A write that adds new enable bits widens the enable word. A write that adds none is taken as a mask or unmask request, and the change is found by comparing the new value with the last value written. Register writes and source events that arrive in the same cycle are applied in a fixed order: the write first, then the event.

Top module: `bitwise_irq_router`

## Requirements
- R1: The block has NUM_OUT outputs (default 10), and status bit i drives `irq_out[i]` only.
- R2: For each selected bit i: if mask bit i or status bit i is set, pending bit i is set and `irq_out[i]` does not change. Otherwise status bit i is set and `irq_out[i]` is asserted.
- R3: A bit is selected only when `src_evt` and `src_level` are both 1, the source line is 1 and the accumulated enable bit is 1. An event with `src_level` at 0 changes nothing. Source bits at NUM_OUT and above never affect status or outputs.
- R4: A status write of zero changes nothing. A status write of all ones clears every status bit and leaves the pending flags and outputs unchanged.
- R5: Any other status write clears the written status bits. Then, for each written bit i below NUM_OUT: if pending bit i is set, status bit i is set again, pending bit i is cleared and `irq_out[i]` stays asserted. Otherwise `irq_out[i]` is deasserted.
- R6: A write to the enable register always updates the value read back from it. If the write adds bits to the accumulated enable word, that word widens and the mask is unchanged. Otherwise, let the change be the old register value XOR the new one. If (change AND new) is non-zero, those changed bits are unmasked. Otherwise, those changed bits are masked.
- R7: Reset clears the enable register, the accumulated enable word, the mask, status, pending and all outputs.
- R8: Status, pending and output are kept separately for each bit. A busy bit never delays a free bit that is selected in the same event.
- R9: `bus_addr` 0 selects the enable register and `bus_addr` 1 selects the status register. Status bits at NUM_OUT and above read as zero. The outputs and status are registered and change at the clock edge that samples the event or write.
- R10: When a register write and an event occur in the same cycle, the event is evaluated against the mask, enable and status that result from the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lines | input | WORD_W | Source line levels |
| src_evt | input | 1 | Source event strobe |
| src_level | input | 1 | Level carried by the event (1 = raise) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Word select: 0 enable, 1 status |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data of the selected register |
| irq_out | output | NUM_OUT | One interrupt output per status bit |

## Verification
The hardest case to reach is a held event that survives an all-ones status clear and is then replayed by a later single-bit clear, while a neighbouring bit drops its own output in the same window. The stimulus builds this up in steps. It first makes one bit busy and fires an event that covers both that bit and a free bit. It then wipes the status word and clears the two bits one at a time. A second hard case is a masked bit that is unmasked in the same cycle an event arrives. The stimulus masks the bit with a shrinking enable write and then drives the restoring write together with the event, so the outcome shows which of the two was applied first.

// File: rtl/bir_pkg.sv
// Package: shared register selector for the per-bit interrupt router.
// Assumes a two-word register window addressed by a single word-select bit.
package bir_pkg;
    typedef enum logic {
        REG_ENABLE = 1'b0,
        REG_STATUS = 1'b1
    } bir_reg_e;
endpackage

// File: rtl/bir_enable_unit.sv
// Module: bir_enable_unit
// Holds the enable register readback value, the accumulated enable word and
// the mask word. It presents the post-write values combinationally, so that
// an event in the same cycle sees them.
// Assumes: wr_i is already qualified with the enable-register address.
module bir_enable_unit #(
    parameter int WORD_W  = 32,
    parameter int NUM_OUT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] reg_o,
    output logic [WORD_W-1:0] acc_nx_o,
    output logic [NUM_OUT-1:0] mask_nx_o
);
    logic [WORD_W-1:0] reg_q, reg_nx;
    logic [WORD_W-1:0] acc_q, acc_nx;
    logic [WORD_W-1:0] mask_q, mask_nx;
    logic [WORD_W-1:0] grown;
    logic [WORD_W-1:0] change;

    // Next-state for the enable readback, the accumulator and the mask
    always_comb begin
        reg_nx  = reg_q;
        acc_nx  = acc_q;
        mask_nx = mask_q;
        grown   = acc_q | wdata_i;
        change  = reg_q ^ wdata_i;
        if (wr_i) begin
            reg_nx = wdata_i;
            if ((wdata_i == '0) && (acc_q == '0)) begin
                acc_nx = acc_q;
            end else if (grown != acc_q) begin
                acc_nx = grown;
            end else if ((change & wdata_i) != '0) begin
                mask_nx = mask_q & ~change;
            end else begin
                mask_nx = mask_q | change;
            end
        end
    end

    // State registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q  <= '0;
            acc_q  <= '0;
            mask_q <= '0;
        end else begin
            reg_q  <= reg_nx;
            acc_q  <= acc_nx;
            mask_q <= mask_nx;
        end
    end

    assign reg_o     = reg_q;
    assign acc_nx_o  = acc_nx;
    assign mask_nx_o = mask_nx[NUM_OUT-1:0];
endmodule

// File: rtl/bir_bit_cell.sv
// Module: bir_bit_cell
// The state of one routed bit: status, pending and output. A status clear is
// applied first and a source event second, both in the same cycle.
// Assumes: clr_i is only asserted when this bit was written as 1 in a
// non-zero status write, and wipe_i marks an all-ones write.
module bir_bit_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic mask_i,
    input  logic clr_i,
    input  logic wipe_i,
    output logic status_o,
    output logic pend_o,
    output logic irq_o
);
    logic st_q, pd_q, ir_q;
    logic st_w, pd_w, ir_w;
    logic st_nx, pd_nx, ir_nx;

    // Stage 1: effect of a status write on this bit
    always_comb begin
        st_w = st_q;
        pd_w = pd_q;
        ir_w = ir_q;
        if (clr_i) begin
            if (wipe_i) begin
                st_w = 1'b0;
            end else if (pd_q) begin
                st_w = 1'b1;
                pd_w = 1'b0;
                ir_w = 1'b1;
            end else begin
                st_w = 1'b0;
                ir_w = 1'b0;
            end
        end
    end

    // Stage 2: effect of a selected source event after the write
    always_comb begin
        st_nx = st_w;
        pd_nx = pd_w;
        ir_nx = ir_w;
        if (sel_i) begin
            if (mask_i || st_w) begin
                pd_nx = 1'b1;
            end else begin
                st_nx = 1'b1;
                ir_nx = 1'b1;
            end
        end
    end

    // Bit state registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= 1'b0;
            pd_q <= 1'b0;
            ir_q <= 1'b0;
        end else begin
            st_q <= st_nx;
            pd_q <= pd_nx;
            ir_q <= ir_nx;
        end
    end

    assign status_o = st_q;
    assign pend_o   = pd_q;
    assign irq_o    = ir_q;
endmodule

// File: rtl/bitwise_irq_router.sv
// Module: bitwise_irq_router (top)
// Routes an enable-qualified source word to NUM_OUT outputs, one per bit.
// Each bit is deferred and replayed on its own. Two-word register window:
// word 0 enable, word 1 status.
// Assumes: NUM_OUT < WORD_W, full-word accesses only.
module bitwise_irq_router #(
    parameter int WORD_W  = 32,
    parameter int NUM_OUT = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  src_lines,
    input  logic               src_evt,
    input  logic               src_level,
    input  logic               bus_wr,
    input  logic               bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic [NUM_OUT-1:0] irq_out
);
    import bir_pkg::*;

    localparam logic [WORD_W-1:0] ALL_ONES = {WORD_W{1'b1}};

    logic              en_wr, st_wr, st_wipe;
    logic              raise;
    logic [WORD_W-1:0] en_reg;
    logic [WORD_W-1:0] acc_nx;
    logic [NUM_OUT-1:0] mask_nx;
    logic [NUM_OUT-1:0] sel_vec;
    logic [NUM_OUT-1:0] status_q;
    logic [NUM_OUT-1:0] pend_q;

    // Write decode for the two registers
    always_comb begin
        en_wr   = bus_wr && (bir_reg_e'(bus_addr) == REG_ENABLE);
        st_wr   = bus_wr && (bir_reg_e'(bus_addr) == REG_STATUS) && (bus_wdata != '0);
        st_wipe = (bus_wdata == ALL_ONES);
        raise   = src_evt && src_level;
    end

    bir_enable_unit #(
        .WORD_W  (WORD_W),
        .NUM_OUT (NUM_OUT)
    ) u_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (en_wr),
        .wdata_i   (bus_wdata),
        .reg_o     (en_reg),
        .acc_nx_o  (acc_nx),
        .mask_nx_o (mask_nx)
    );

    // Source selection against the post-write enable word
    always_comb begin
        sel_vec = raise ? (src_lines[NUM_OUT-1:0] & acc_nx[NUM_OUT-1:0]) : '0;
    end

    for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_bit
        bir_bit_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_i    (sel_vec[gi]),
            .mask_i   (mask_nx[gi]),
            .clr_i    (st_wr && bus_wdata[gi]),
            .wipe_i   (st_wipe),
            .status_o (status_q[gi]),
            .pend_o   (pend_q[gi]),
            .irq_o    (irq_out[gi])
        );
    end

    // Read mux: enable readback or zero-extended status
    always_comb begin
        if (bir_reg_e'(bus_addr) == REG_ENABLE) begin
            bus_rdata = en_reg;
        end else begin
            bus_rdata = WORD_W'(status_q);
        end
    end
endmodule

// File: rtl/bir_checker.sv
// Module: bir_checker
// Temporal checks on the router, attached to the top module by bind.
// Assumes: it is connected to the top's ports and to its status and pending vectors.
module bir_checker #(
    parameter int WORD_W  = 32,
    parameter int NUM_OUT = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               src_evt,
    input logic               src_level,
    input logic               bus_wr,
    input logic               bus_addr,
    input logic [WORD_W-1:0]  bus_wdata,
    input logic [WORD_W-1:0]  bus_rdata,
    input logic [NUM_OUT-1:0] irq_out,
    input logic [NUM_OUT-1:0] status_q,
    input logic [NUM_OUT-1:0] pend_q
);
    // R7
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0 && status_q == '0 && pend_q == '0));

    // R2
    rise_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & ~$past(irq_out) & ~status_q) == '0));

    // R3
    low_level_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt && !src_level && !bus_wr) |=> ($stable(irq_out) && $stable(status_q)));

    // R4
    zero_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && bus_wdata == '0 && !src_evt) |=> ($stable(status_q) && $stable(irq_out)));

    // R4
    wipe_keeps_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && (&bus_wdata) && !src_evt) |=>
            (status_q == '0 && $stable(irq_out) && $stable(pend_q)));

    // R9
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr |-> (bus_rdata[WORD_W-1:NUM_OUT] == '0));
endmodule

bind bitwise_irq_router bir_checker #(
    .WORD_W  (WORD_W),
    .NUM_OUT (NUM_OUT)
) u_bir_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_evt   (src_evt),
    .src_level (src_level),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .status_q  (status_q),
    .pend_q    (pend_q)
);

// File: tb/bitwise_irq_router_bench.sv
module bitwise_irq_router_bench;
    localparam int WORD_W  = 32;
    localparam int NUM_OUT = 10;
    localparam int MAX_CYC = 200000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [WORD_W-1:0]  src_lines = '0;
    logic               src_evt = 1'b0;
    logic               src_level = 1'b0;
    logic               bus_wr = 1'b0;
    logic               bus_addr = 1'b1;
    logic [WORD_W-1:0]  bus_wdata = '0;
    logic [WORD_W-1:0]  bus_rdata;
    logic [NUM_OUT-1:0] irq_out;

    typedef struct {
        string              tag;
        bit                 chk_irq;
        logic [NUM_OUT-1:0] irq;
        logic [WORD_W-1:0]  rd;
    } exp_t;

    exp_t sb_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #2 clk = ~clk;

    bitwise_irq_router #(
        .WORD_W  (WORD_W),
        .NUM_OUT (NUM_OUT)
    ) u_bitwise_irq_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_lines (src_lines),
        .src_evt   (src_evt),
        .src_level (src_level),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // One cycle of stimulus: optional write and optional event
    task automatic step(input bit wr, input bit addr, input logic [WORD_W-1:0] data,
                        input bit evt, input bit lvl, input logic [WORD_W-1:0] lines);
        @(negedge clk);
        bus_wr    = wr;
        bus_addr  = addr;
        bus_wdata = data;
        src_evt   = evt;
        src_level = lvl;
        src_lines = lines;
        @(negedge clk);
        bus_wr   = 1'b0;
        src_evt  = 1'b0;
        bus_addr = 1'b1;
    endtask

    task automatic wr_en(input logic [WORD_W-1:0] d);  step(1, 0, d, 0, 0, '0); endtask
    task automatic wr_st(input logic [WORD_W-1:0] d);  step(1, 1, d, 0, 0, '0); endtask
    task automatic fire(input logic [WORD_W-1:0] l, input bit lvl); step(0, 1, '0, 1, lvl, l); endtask

    // Push expected outputs and status readback
    task automatic exp_st(input string tag, input logic [NUM_OUT-1:0] irq, input logic [WORD_W-1:0] st);
        exp_t e;
        bus_addr = 1'b1;
        e.tag = tag; e.chk_irq = 1'b1; e.irq = irq; e.rd = st;
        sb_q.push_back(e);
        #2;
    endtask

    // Push expected enable readback
    task automatic exp_en(input string tag, input logic [WORD_W-1:0] en);
        exp_t e;
        bus_addr = 1'b0;
        e.tag = tag; e.chk_irq = 1'b0; e.irq = '0; e.rd = en;
        sb_q.push_back(e);
        #2;
        bus_addr = 1'b1;
    endtask

    // Monitor: pop each expected item and compare against the ports
    initial begin
        forever begin
            exp_t e;
            wait (sb_q.size() != 0);
            #1;
            e = sb_q.pop_front();
            n_cmp++;
            if (e.chk_irq && (irq_out !== e.irq)) begin
                n_bad++;
                $display("FAIL %s irq_out actual=%h expected=%h", e.tag, irq_out, e.irq);
            end
            if (bus_rdata !== e.rd) begin
                n_bad++;
                $display("FAIL %s rdata actual=%h expected=%h", e.tag, bus_rdata, e.rd);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_st("R7 reset status", 10'h000, 32'h0);
        exp_en("R7 reset enable", 32'h0);

        wr_en(32'h0000_000F);
        exp_en("R6 enable readback", 32'h0000_000F);
        fire(32'h3, 1);          exp_st("R1 bits0,1 routed", 10'h003, 32'h3);
        fire(32'h1, 1);          exp_st("R2 busy bit held", 10'h003, 32'h3);
        fire(32'h4, 0);          exp_st("R3 low level ignored", 10'h003, 32'h3);
        fire(32'h30, 1);         exp_st("R3 disabled lines ignored", 10'h003, 32'h3);
        wr_st(32'h0);            exp_st("R4 zero write ignored", 10'h003, 32'h3);
        wr_st(32'h1);            exp_st("R5 replay bit0", 10'h003, 32'h3);
        wr_st(32'h1);            exp_st("R5 drop bit0", 10'h002, 32'h2);
        wr_st(32'h2);            exp_st("R5 drop bit1", 10'h000, 32'h0);

        wr_en(32'h0000_0007);
        exp_en("R6 shrinking write readback", 32'h7);
        fire(32'h8, 1);          exp_st("R2 masked bit held", 10'h000, 32'h0);
        wr_en(32'h0000_000F);    exp_st("R6 unmask no output", 10'h000, 32'h0);
        fire(32'h8, 1);          exp_st("R6 unmasked bit fires", 10'h008, 32'h8);
        wr_st(32'h8);            exp_st("R5 replay masked event", 10'h008, 32'h8);
        wr_st(32'h8);            exp_st("R5 drop bit3", 10'h000, 32'h0);

        fire(32'h3, 1);          exp_st("R1 two bits", 10'h003, 32'h3);
        fire(32'h6, 1);          exp_st("R8 free bit not delayed", 10'h007, 32'h7);
        wr_st(32'h1);            exp_st("R8 bit0 drops alone", 10'h006, 32'h6);
        wr_st(32'hFFFF_FFFF);    exp_st("R4 wipe keeps outputs", 10'h006, 32'h0);
        wr_st(32'h2);            exp_st("R5 pending survives wipe", 10'h006, 32'h2);
        wr_st(32'h4);            exp_st("R5 drop after wipe", 10'h002, 32'h2);
        wr_st(32'h2);            exp_st("R5 last drop", 10'h000, 32'h0);

        wr_en(32'h0000_0C0F);
        exp_en("R6 growing write readback", 32'h0000_0C0F);
        fire(32'hFFFF_FC00, 1);  exp_st("R9 upper bits ignored", 10'h000, 32'h0);
        wr_en(32'h0000_0C0E);    exp_st("R6 mask bit0", 10'h000, 32'h0);
        step(1, 0, 32'h0000_0C0F, 1, 1, 32'h1);
        exp_st("R10 unmask applied before event", 10'h001, 32'h1);
        wr_st(32'h1);            exp_st("R10 nothing left pending", 10'h000, 32'h0);

        wait (sb_q.size() == 0);
        #3;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule